// File: doc/BRIEF.md
# Frequency Sweep Tuning-Word Generator

This block steps a frequency value through a programmable range for a direct digital synthesizer and turns that value into the phase tuning word the synthesizer expects. Three 26-bit range registers hold the sweep floor, the sweep ceiling and the increment. All three are written through one shared data bus. A 2-bit selector picks the target, and a load-enable input qualifies the write.

A separate update strobe drives the sweep. The block samples the strobe on the system clock and detects its rising edge. On each rising edge the frequency value either grows by the increment or falls back to the floor, depending on whether it already lies above the ceiling. A registered multiply by a fixed constant gives the 32-bit tuning word. The block also provides the tuning word in 40-bit form with a zero upper byte, ready for a serialiser placed downstream.

Top module: `sweep_tuning_gen`

## Requirements
- R1: After reset, the floor is 300, the increment is 1000, the ceiling is 10,000,000 and the frequency output is 300. The tuning word then matches frequency 300.
- R2: When load-enable is high at a clock edge, the bus value is written to the floor if the selector is 2'b00, to the ceiling if it is 2'b01, and to the increment if it is 2'b10.
- R3: Selector value 2'b11 with load-enable high changes none of the three range registers.
- R4: When load-enable is low, the bus and the selector have no effect on the range registers.
- R5: On a rising edge of the strobe, if the frequency is above the ceiling, the frequency becomes the floor. Otherwise the increment is added to it. The new value appears on the clock edge that samples the strobe high for the first time.
- R6: The wrap test is strictly greater-than. A frequency equal to the ceiling receives the increment.
- R7: Holding the strobe high across several clocks produces exactly one sweep step.
- R8: The addition is unsigned modulo 2^26, and the carry out of bit 25 is dropped.
- R9: The tuning word is bits 57:26 of the 58-bit product of the frequency and 32'hABCC7711. It is registered, so it reflects the frequency one clock after the frequency changes.
- R10: The 40-bit output holds 8'h00 in bits 39:32 and the tuning word in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Qualifies a range-register write |
| ld_sel | input | 2 | Range register target: 00 floor, 01 ceiling, 10 increment, 11 none |
| ld_data | input | 26 | Shared write data |
| step_strobe | input | 1 | Sweep update request, active on its rising edge |
| freq_out | output | 26 | Current frequency value |
| tune_word | output | 32 | Phase tuning word |
| synth_word | output | 40 | Zero byte followed by the tuning word |

## Verification
The bound checker checks on every cycle that the frequency holds when no strobe edge occurs and that it takes exactly the floor or the incremented value after an edge. It also checks that the tuning word follows the previous cycle's frequency through the truncated product, that the 40-bit word is framed correctly, and that the range registers stay unchanged for disabled or 2'b11 writes. Some behaviour can only be shown by the bench scenarios: that real programming sequences steer a sweep through the ceiling (including the equal-to-ceiling case), the reset defaults seen at the outputs, the 26-bit rollover, and a long strobe pulse giving a single step.

// File: rtl/sweep_tuning_gen.sv
module sweep_tuning_gen #(
  parameter int          FW        = 26,
  parameter int          TW        = 32,
  parameter logic [31:0] TUNE_MULT = 32'hABCC7711,
  parameter int          LO_INIT   = 300,
  parameter int          STEP_INIT = 1000,
  parameter int          HI_INIT   = 10_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [1:0]      ld_sel,
  input  logic [FW-1:0]   ld_data,
  input  logic            step_strobe,
  output logic [FW-1:0]   freq_out,
  output logic [TW-1:0]   tune_word,
  output logic [TW+7:0]   synth_word
);
  localparam int PW = FW + TW;

  function automatic logic [TW-1:0] to_tune(input logic [FW-1:0] f);
    logic [PW-1:0] prod;
    prod = {{TW{1'b0}}, f} * {{FW{1'b0}}, TUNE_MULT[TW-1:0]};
    return prod[PW-1 -: TW];
  endfunction

  localparam logic [FW-1:0] LO_RST   = FW'(LO_INIT);
  localparam logic [FW-1:0] STEP_RST = FW'(STEP_INIT);
  localparam logic [FW-1:0] HI_RST   = FW'(HI_INIT);
  localparam logic [TW-1:0] TUNE_RST = to_tune(LO_RST);

  logic [FW-1:0] lo_q, hi_q, step_q, freq_q;
  logic          strobe_q;
  logic          rise;
  logic [FW-1:0] freq_nxt;

  assign rise     = step_strobe & ~strobe_q;
  assign freq_nxt = (freq_q > hi_q) ? lo_q : freq_q + step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= LO_RST;
      hi_q   <= HI_RST;
      step_q <= STEP_RST;
    end else if (ld_en) begin
      case (ld_sel)
        2'b00:   lo_q   <= ld_data;
        2'b01:   hi_q   <= ld_data;
        2'b10:   step_q <= ld_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      freq_q    <= LO_RST;
      tune_word <= TUNE_RST;
    end else begin
      strobe_q  <= step_strobe;
      if (rise) freq_q <= freq_nxt;
      tune_word <= to_tune(freq_q);
    end
  end

  assign freq_out   = freq_q;
  assign synth_word = {8'h00, tune_word};
endmodule

module sweep_tuning_chk #(
  parameter int          FW        = 26,
  parameter int          TW        = 32,
  parameter logic [31:0] TUNE_MULT = 32'hABCC7711
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_en,
  input logic [1:0]    ld_sel,
  input logic          step_strobe,
  input logic [FW-1:0] freq_out,
  input logic [TW-1:0] tune_word,
  input logic [TW+7:0] synth_word,
  input logic [FW-1:0] lo_q,
  input logic [FW-1:0] hi_q,
  input logic [FW-1:0] step_q
);
  localparam int PW = FW + TW;
  logic          seen_hi;
  logic [PW-1:0] ref_prod;
  logic [FW-1:0] ref_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_hi <= 1'b0;
    else        seen_hi <= step_strobe;
  end

  assign ref_prod = {{TW{1'b0}}, freq_out} * {{FW{1'b0}}, TUNE_MULT[TW-1:0]};
  assign ref_sum  = freq_out + step_q;

  // R5
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_strobe |=> $stable(freq_out));
  // R7
  held_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_strobe && seen_hi) |=> $stable(freq_out));
  // R5
  wrap_to_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_strobe && !seen_hi && freq_out > hi_q) |=> freq_out == $past(lo_q));
  // R6
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_strobe && !seen_hi && freq_out <= hi_q) |=> freq_out == $past(ref_sum));
  // R9
  tune_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tune_word == $past(ref_prod[PW-1 -: TW]));
  // R10
  frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    synth_word == {8'h00, tune_word});
  // R3
  sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 2'b11) |=> ($stable(lo_q) && $stable(hi_q) && $stable(step_q)));
  // R4
  load_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ($stable(lo_q) && $stable(hi_q) && $stable(step_q)));
endmodule

bind sweep_tuning_gen sweep_tuning_chk #(.FW(FW), .TW(TW), .TUNE_MULT(TUNE_MULT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
  .step_strobe(step_strobe), .freq_out(freq_out), .tune_word(tune_word),
  .synth_word(synth_word), .lo_q(lo_q), .hi_q(hi_q), .step_q(step_q)
);

// File: tb/test_sweep_tuning_gen.sv
module test_sweep_tuning_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = 2'b00;
  logic [25:0] ld_data = '0;
  logic        step_strobe = 1'b0;
  logic [25:0] freq_out;
  logic [31:0] tune_word;
  logic [39:0] synth_word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [25:0] f;
    logic [31:0] t;
  } item_t;
  item_t q[$];

  logic [25:0] m_lo = 26'd300, m_hi = 26'd10_000_000, m_step = 26'd1000, m_freq = 26'd300;

  always #(CLK_PERIOD/2) clk = ~clk;

  sweep_tuning_gen i_sweep_tuning_gen (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .step_strobe(step_strobe), .freq_out(freq_out), .tune_word(tune_word),
    .synth_word(synth_word)
  );

  function automatic logic [31:0] m_tune(input logic [25:0] f);
    logic [63:0] p;
    p = {38'd0, f} * 64'h00000000ABCC7711;
    return p[57:26];
  endfunction

  task automatic push(input string tag, input logic [25:0] f, input logic [31:0] t);
    item_t it;
    it.tag = tag; it.f = f; it.t = t;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (freq_out !== it.f) begin
        errors++;
        $display("FAIL %s freq_out got %0d exp %0d", it.tag, freq_out, it.f);
      end
      checks++;
      if (tune_word !== it.t) begin
        errors++;
        $display("FAIL %s R9 tune_word got %h exp %h", it.tag, tune_word, it.t);
      end
      checks++;
      if (synth_word !== {8'h00, it.t}) begin
        errors++;
        $display("FAIL %s R10 synth_word got %h exp %h", it.tag, synth_word, {8'h00, it.t});
      end
    end
  end

  task automatic load(input bit en, input logic [1:0] sel, input logic [25:0] d);
    @(negedge clk);
    ld_en = en; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    if (en) begin
      case (sel)
        2'b00: m_lo = d;
        2'b01: m_hi = d;
        2'b10: m_step = d;
        default: ;
      endcase
    end
  endtask

  task automatic sweep(input string tag, input int hold);
    logic [31:0] old_t;
    old_t = m_tune(m_freq);
    @(negedge clk);
    step_strobe = 1'b1;
    @(posedge clk); #1;
    m_freq = (m_freq > m_hi) ? m_lo : m_freq + m_step;
    push({tag, " R9 lag"}, m_freq, old_t);
    repeat (hold) @(negedge clk);
    step_strobe = 1'b0;
    @(posedge clk); #1;
    push(tag, m_freq, m_tune(m_freq));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 push("R1 reset", 26'd300, m_tune(26'd300));
    @(negedge clk);

    sweep("R1 R5 default step", 1);
    sweep("R5 step", 1);
    sweep("R5 step", 1);

    load(1'b1, 2'b00, 26'd100);
    load(1'b1, 2'b01, 26'd1500);
    load(1'b1, 2'b10, 26'd700);
    sweep("R2 R5 wrap to new floor", 1);
    sweep("R2 new step", 1);
    sweep("R6 reach ceiling", 1);
    sweep("R6 equal adds", 1);
    sweep("R5 above wraps", 1);

    load(1'b0, 2'b10, 26'd5);
    sweep("R4 disabled load", 1);
    load(1'b1, 2'b11, 26'd9);
    sweep("R3 selector 11", 1);
    sweep("R7 held strobe", 4);

    load(1'b1, 2'b00, 26'h3FFFFF0);
    load(1'b1, 2'b01, 26'd0);
    sweep("R5 wrap to high floor", 1);
    load(1'b1, 2'b01, 26'h3FFFFFF);
    load(1'b1, 2'b10, 26'h20);
    sweep("R8 rollover", 1);
    sweep("R8 after rollover", 1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule